// File: doc/BRIEF.md
# Command-FIFO SPI Flash Sequencer

This block builds serial flash traffic out of small command words. Software writes each word through a write port into a command FIFO. A prefetch register takes the next word from the FIFO while the current one runs. An executor then carries out the words one at a time on a one-, two- or four-lane SPI bus. Each word does one of four things. It can idle for a number of SPI clock periods, shift out one opcode byte, shift out one address byte, or run dummy clocks. Every word also carries its own active-low chip-select code, so a complete flash transaction is a run of words. It opens with an idle that has no device selected, then an idle with the device selected to give setup time. The opcode, address and dummy words follow, and a closing idle gives hold time.

A configuration word sets four things: the lane width used by opcode words, the lane width used by address words, the clock polarity and phase, and the divider that derives the SPI clock from the bus clock. The status word reports how many commands are still pending and whether a write was ever lost to a full FIFO. The pending count covers the FIFO, the prefetch register and the executing command. Because of this, software waits for a pending count of zero, not for an empty FIFO. The configuration must only be changed while the pending count is zero.

Top module: `spi_cmd_seq`

## Requirements
- R1: A command word is 18 bits. Bits [17:14] are the type, bits [13:10] are the chip-select code, and bits [9:0] are the argument. Type 0x5 shifts out the opcode byte in bits [7:0] and type 0x6 shifts out the address byte in bits [7:0]. The byte is sent MSB first on the lanes chosen by that phase's lane field: code 0 uses io[0], code 1 uses io[1:0] and code 2 uses io[3:0]. Within a transfer, the higher io index carries the earlier bit. A byte takes 8/lanes SPI clock periods. The lanes in use are driven (io_oe set on exactly those lanes), and no lane is driven outside opcode and address commands.
- R2: From its first bus cycle, each command drives cs_n[1:0] from bits [1:0] of its chip-select code: 0xF selects no device, 0xE selects device 0 (cs_n=2'b10) and 0xD selects device 1 (cs_n=2'b01). The level holds after the command ends.
- R3: Type 0xC idles for the argument's count of SPI clock periods. During those periods sclk stays at its idle level and no lane is driven. Each command costs one bus cycle to load, on top of its SPI clock periods.
- R4: Type 0xB runs argument+1 SPI clock periods with all lanes released.
- R5: One SPI clock period lasts (divider field + 1) bus clocks. The field resets to 3, which gives a divide of 4. A field of 0 is treated as 1.
- R6: With clock phase 0, data changes at the start of each period and the leading sclk edge falls at mid-period. With clock phase 1, the leading edge falls at the start of the period. The sclk idle level equals the polarity bit.
- R7: Status bits [26:22] hold the number of pending commands, counted over the FIFO, the prefetch register and the executing command.
- R8: A command write that arrives while the FIFO is full is dropped and sets the sticky status bit 31. Only reset clears that bit.
- R9: Any other type value behaves as an idle of zero periods: it applies its chip-select code and produces no sclk edge.
- R10: After reset, no device is selected, sclk is low, no lane is driven and the status word is zero.
- R11: The configuration word is 10 bits. Bits [1:0] hold the opcode lane code, bits [3:2] the address lane code, bit 4 the clock phase, bit 5 the clock polarity and bits [9:6] the divider field. A lane code of 3 behaves as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Push cmd_word into the command FIFO |
| cmd_word | input | 18 | Command word (type, chip-select code, argument) |
| cfg_wr | input | 1 | Load cfg_word into the configuration register |
| cfg_word | input | 10 | Lane codes, clock phase, clock polarity, divider field |
| status | output | 32 | Pending count in [26:22], sticky overflow in bit 31 |
| sclk | output | 1 | SPI clock |
| cs_n | output | 2 | Active-low device selects |
| io_out | output | 4 | Serial data lanes |
| io_oe | output | 4 | Per-lane drive enable |

## Verification
The hardest state to reach from the ports is the one where the FIFO is full while both the prefetch register and the executor are occupied. Only there do the overflow drop and the full pending count of FIFO depth plus two appear. The bench reaches it by pushing a burst of long idle commands on back-to-back cycles. The first command is still executing when the burst ends, so the burst outruns the drain and the count and flag can be read before any command retires. Lane-width and mode coverage comes from a port-side monitor. It decodes bits at the sampling edge that the configured phase defines, then matches each reassembled byte, its lane pattern and its chip-select against a queue filled by the driver.

// File: rtl/spi_seq_pkg.sv
// Shared types for the command-FIFO SPI sequencer.
// Holds the command decode, the configuration layout and the lane helpers.
// Assumes the 18-bit command word layout {type[3:0], cs[3:0], arg[9:0]}.
package spi_seq_pkg;

    localparam int CMD_W = 18;
    localparam int CFG_W = 10;
    localparam int ARG_W = 10;

    localparam logic [3:0] TYPE_OPC   = 4'h5;
    localparam logic [3:0] TYPE_ADDR  = 4'h6;
    localparam logic [3:0] TYPE_DUMMY = 4'hB;
    localparam logic [3:0] TYPE_IDLE  = 4'hC;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_OPC   = 2'd1,
        K_ADDR  = 2'd2,
        K_DUMMY = 2'd3
    } op_kind_t;

    typedef struct packed {
        op_kind_t           kind;
        logic [3:0]         cs;
        logic [ARG_W-1:0]   arg;
    } op_t;

    typedef struct packed {
        logic [3:0] div_m1;
        logic       cpol;
        logic       cpha;
        logic [1:0] addr_lanes;
        logic [1:0] opc_lanes;
    } cfg_t;

    // Turn a raw command word into a decoded operation; unknown types become a zero idle.
    function automatic op_t decode_word(input logic [CMD_W-1:0] w);
        op_t o;
        o.cs  = w[13:10];
        o.arg = w[9:0];
        case (w[17:14])
            TYPE_OPC:   o.kind = K_OPC;
            TYPE_ADDR:  o.kind = K_ADDR;
            TYPE_DUMMY: o.kind = K_DUMMY;
            TYPE_IDLE:  o.kind = K_IDLE;
            default: begin
                o.kind = K_IDLE;
                o.arg  = '0;
            end
        endcase
        return o;
    endfunction

    // Bits moved per SPI period for a lane code (code 3 acts as quad).
    function automatic logic [2:0] lane_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Drive-enable pattern for a lane code.
    function automatic logic [3:0] lane_mask(input logic [1:0] code);
        case (code)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/cmd_fifo.sv
// Synchronous FIFO for command words.
// A push while full is dropped (the caller flags it); pop on empty is ignored.
// Assumes DEPTH >= 2; the pointers wrap explicitly, so any depth works.
module cmd_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/seq_exec.sv
// Executor stage: runs one decoded command at a time on the SPI pins.
// It derives sclk from a bus-clock phase counter, shifts opcode and address
// bytes out MSB first, and holds the chip-select code after each command.
// Assumes cfg only changes while the executor is idle.
module seq_exec #(
    parameter int DIV_W = 4,
    localparam int CNT_W = spi_seq_pkg::ARG_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  spi_seq_pkg::op_t     op,
    input  spi_seq_pkg::cfg_t    cfg,
    output logic                 busy,
    output logic                 sclk,
    output logic [1:0]           cs_n,
    output logic [3:0]           io_out,
    output logic [3:0]           io_oe
);
    import spi_seq_pkg::*;

    op_kind_t          kind;
    logic [3:0]        cs_code;
    logic [DIV_W-1:0]  ph;
    logic [DIV_W-1:0]  div_last;
    logic [CNT_W-1:0]  rem;
    logic [7:0]        shreg;
    logic [1:0]        lcode;

    logic [CNT_W-1:0]  periods;
    logic [1:0]        load_lcode;
    logic [DIV_W:0]    half;
    logic              toggling, active, driving;

    // Periods and lane code a freshly loaded command needs.
    always_comb begin
        load_lcode = (op.kind == K_ADDR) ? cfg.addr_lanes : cfg.opc_lanes;
        case (op.kind)
            K_IDLE:  periods = CNT_W'(op.arg);
            K_DUMMY: periods = CNT_W'(op.arg) + 1'b1;
            default: periods = CNT_W'(4'd8 >> (lane_bits(load_lcode) >> 1));
        endcase
    end

    // Command state: load, advance the phase counter, shift, retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            kind     <= K_IDLE;
            cs_code  <= 4'hF;
            ph       <= '0;
            div_last <= DIV_W'(3);
            rem      <= '0;
            shreg    <= '0;
            lcode    <= '0;
        end else if (load) begin
            busy     <= (periods != '0);
            kind     <= op.kind;
            cs_code  <= op.cs;
            ph       <= '0;
            div_last <= (cfg.div_m1 == '0) ? DIV_W'(1) : DIV_W'(cfg.div_m1);
            rem      <= periods;
            shreg    <= op.arg[7:0];
            lcode    <= load_lcode;
        end else if (busy) begin
            if (ph == div_last) begin
                ph    <= '0;
                rem   <= rem - 1'b1;
                shreg <= shreg << lane_bits(lcode);
                if (rem == CNT_W'(1)) busy <= 1'b0;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // Pin generation from the registered state.
    always_comb begin
        half     = ({1'b0, div_last} + 1'b1) >> 1;
        toggling = busy && (kind != K_IDLE);
        active   = cfg.cpha ? ({1'b0, ph} < half) : ({1'b0, ph} >= half);
        sclk     = cfg.cpol ^ (toggling && active);
        driving  = busy && ((kind == K_OPC) || (kind == K_ADDR));
        io_oe    = driving ? lane_mask(lcode) : 4'b0000;
        case (lcode)
            2'd0:    io_out = {3'b000, shreg[7]};
            2'd1:    io_out = {2'b00, shreg[7:6]};
            default: io_out = shreg[7:4];
        endcase
        if (!driving) io_out = 4'b0000;
        cs_n = cs_code[1:0];
    end

    // R1
    lane_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));
    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind == K_IDLE) |-> (sclk == cfg.cpol && io_oe == 4'b0000));
    // R4
    dummy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind == K_DUMMY) |-> (io_oe == 4'b0000));
    // R6
    rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg.cpol));

endmodule

// File: rtl/spi_cmd_seq.sv
// Top of the command-FIFO SPI sequencer: configuration register, command
// FIFO, one-word prefetch stage and executor. Status reports the pending
// count (FIFO + prefetch + executing) and a sticky overflow flag.
// Assumes FIFO_DEPTH + 2 fits the 5-bit pending field.
module spi_cmd_seq #(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 4,
    localparam int CW        = $clog2(FIFO_DEPTH + 1),
    localparam int PEND_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_wr,
    input  logic [spi_seq_pkg::CMD_W-1:0] cmd_word,
    input  logic                          cfg_wr,
    input  logic [spi_seq_pkg::CFG_W-1:0] cfg_word,
    output logic [31:0]                   status,
    output logic                          sclk,
    output logic [1:0]                    cs_n,
    output logic [3:0]                    io_out,
    output logic [3:0]                    io_oe
);
    import spi_seq_pkg::*;

    cfg_t               cfg;
    logic               ovf;
    logic [CMD_W-1:0]   fifo_dout;
    logic               fifo_full, fifo_empty, fifo_pop;
    logic [CW-1:0]      fifo_count;
    logic               pre_valid;
    op_t                pre_op;
    logic               exec_busy, exec_load;
    logic [PEND_W-1:0]  pending;

    // Configuration register; the divider field resets to a divide of 4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg.div_m1 <= 4'd3;
        end else if (cfg_wr) begin
            cfg <= cfg_t'(cfg_word);
        end
    end

    // Sticky overflow on a write the full FIFO cannot take.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else if (cmd_wr && fifo_full) ovf <= 1'b1;
    end

    cmd_fifo #(.WIDTH(CMD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_wr),
        .din   (cmd_word),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_count)
    );

    assign exec_load = pre_valid && !exec_busy;
    assign fifo_pop  = !fifo_empty && (!pre_valid || exec_load);

    // Prefetch stage: holds the next decoded command while one executes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_valid <= 1'b0;
            pre_op    <= '0;
        end else if (fifo_pop) begin
            pre_valid <= 1'b1;
            pre_op    <= decode_word(fifo_dout);
        end else if (exec_load) begin
            pre_valid <= 1'b0;
        end
    end

    seq_exec #(.DIV_W(DIV_W)) u_exec (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (exec_load),
        .op     (pre_op),
        .cfg    (cfg),
        .busy   (exec_busy),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    // Pending work across all three stages, packed into the status word.
    always_comb begin
        pending = PEND_W'(fifo_count) + PEND_W'(pre_valid) + PEND_W'(exec_busy);
        status  = {ovf, 4'b0000, pending, 22'd0};
    end

    // R7
    pending_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_W'(FIFO_DEPTH + 2));
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R7
    prefetch_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count != '0) |-> (pre_valid || !$past(fifo_empty) || $past(exec_load) || $past(cmd_wr)));

endmodule

// File: tb/spi_cmd_seq_test.sv
// Scoreboard bench: the driver queues expected bytes, the pin monitor
// reassembles bytes at the sampling edge and compares them.
module spi_cmd_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [17:0] cmd_word = '0;
    logic        cfg_wr = 1'b0;
    logic [9:0]  cfg_word = '0;
    logic [31:0] status;
    logic        sclk;
    logic [1:0]  cs_n;
    logic [3:0]  io_out, io_oe;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Monitor state and mode mirrors.
    bit          tb_cpol = 1'b0, tb_cpha = 1'b0;
    logic        prev_sclk = 1'b0;
    int          cyc = 0, last_lead = -1, min_period = 999;
    int          edge_cnt = 0, dummy_cnt = 0;
    logic [7:0]  acc = '0;
    int          nbits = 0;
    logic [13:0] expq[$];

    always #2 clk = ~clk;

    spi_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cfg_wr(cfg_wr), .cfg_word(cfg_word), .status(status),
        .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] mk(input logic [3:0] t, input logic [3:0] cs, input logic [9:0] a);
        return {t, cs, a};
    endfunction

    task automatic push(input logic [17:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_word = w;
        @(posedge clk);
        #1 cmd_wr = 1'b0;
    endtask

    task automatic set_cfg(input logic [9:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_word = v;
        tb_cpha = v[4];
        tb_cpol = v[5];
        @(posedge clk);
        #1 cfg_wr = 1'b0;
    endtask

    task automatic expect_byte(input logic [7:0] b, input logic [3:0] oe, input logic [1:0] cs);
        expq.push_back({cs, oe, b});
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (status[26:22] == 5'd0) break;
        end
    endtask

    // Pin monitor: sample at the phase-defined edge, rebuild bytes, score them.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (sclk != prev_sclk) begin
                automatic bit lead = (prev_sclk == tb_cpol);
                edge_cnt++;
                if (lead && cs_n != 2'b11) begin
                    if (last_lead >= 0 && (cyc - last_lead) < min_period) min_period = cyc - last_lead;
                    last_lead = cyc;
                end
                if ((tb_cpha ? !lead : lead) && cs_n != 2'b11) begin
                    if (io_oe == 4'b0000) dummy_cnt++;
                    else begin
                        case (io_oe)
                            4'b0001: begin acc = {acc[6:0], io_out[0]};   nbits += 1; end
                            4'b0011: begin acc = {acc[5:0], io_out[1:0]}; nbits += 2; end
                            default: begin acc = {acc[3:0], io_out[3:0]}; nbits += 4; end
                        endcase
                        if (nbits >= 8) begin
                            nbits = 0;
                            if (expq.size() == 0)
                                chk(1'b0, "R1 unexpected byte", int'(acc), 0);
                            else begin
                                automatic logic [13:0] e = expq.pop_front();
                                chk(acc == e[7:0], "R1 byte value", int'(acc), int'(e[7:0]));
                                chk(io_oe == e[11:8], "R1 lane enables", int'(io_oe), int'(e[11:8]));
                                chk(cs_n == e[13:12], "R2 chip select", int'(cs_n), int'(e[13:12]));
                            end
                        end
                    end
                end
            end
            prev_sclk = sclk;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(cs_n == 2'b11, "R10 cs_n", int'(cs_n), 3);
        chk(sclk == 1'b0, "R10 sclk", int'(sclk), 0);
        chk(io_oe == 4'b0000, "R10 io_oe", int'(io_oe), 0);
        chk(status == 32'd0, "R10 status", int'(status), 0);

        // R1 R2 R5 single-lane transaction on device 0, default divide
        min_period = 999; last_lead = -1;
        expect_byte(8'h9F, 4'b0001, 2'b10);
        expect_byte(8'h12, 4'b0001, 2'b10);
        expect_byte(8'hA5, 4'b0001, 2'b10);
        push(mk(4'hC, 4'hF, 10'd2));
        push(mk(4'hC, 4'hE, 10'd1));
        push(mk(4'h5, 4'hE, 10'h09F));
        push(mk(4'h6, 4'hE, 10'h012));
        push(mk(4'h6, 4'hE, 10'h0A5));
        push(mk(4'hC, 4'hE, 10'd2));
        push(mk(4'hC, 4'hF, 10'd0));
        wait_idle();
        chk(cs_n == 2'b11, "R2 deselect after end", int'(cs_n), 3);
        chk(min_period == 4, "R5 default sclk period", min_period, 4);
        chk(expq.size() == 0, "R1 bytes seen", expq.size(), 0);

        // R1 R4 R11 dual opcode, quad address, dummy on device 1
        set_cfg(10'b0011_0_0_10_01);
        dummy_cnt = 0;
        expect_byte(8'h3B, 4'b0011, 2'b01);
        expect_byte(8'hC6, 4'b1111, 2'b01);
        expect_byte(8'h5E, 4'b1111, 2'b01);
        push(mk(4'hC, 4'hD, 10'd1));
        push(mk(4'h5, 4'hD, 10'h03B));
        push(mk(4'h6, 4'hD, 10'h0C6));
        push(mk(4'h6, 4'hD, 10'h05E));
        push(mk(4'hB, 4'hD, 10'd7));
        push(mk(4'hC, 4'hD, 10'd2));
        push(mk(4'hC, 4'hF, 10'd0));
        wait_idle();
        chk(dummy_cnt == 8, "R4 dummy clocks", dummy_cnt, 8);
        chk(expq.size() == 0, "R1 multi-lane bytes seen", expq.size(), 0);

        // R6 R5 polarity 1, phase 1, divide of 6
        set_cfg(10'b0101_1_1_00_00);
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R6 idle level with polarity 1", int'(sclk), 1);
        min_period = 999; last_lead = -1;
        expect_byte(8'h0B, 4'b0001, 2'b10);
        expect_byte(8'h80, 4'b0001, 2'b10);
        push(mk(4'hC, 4'hE, 10'd1));
        push(mk(4'h5, 4'hE, 10'h00B));
        push(mk(4'h6, 4'hE, 10'h080));
        push(mk(4'hC, 4'hE, 10'd2));
        push(mk(4'hC, 4'hF, 10'd0));
        wait_idle();
        chk(min_period == 6, "R5 divided sclk period", min_period, 6);
        chk(expq.size() == 0, "R6 mode 3 bytes seen", expq.size(), 0);

        // R3 idle timing: 2 staging cycles + 10 periods of 4 bus clocks
        set_cfg(10'b0011_0_0_00_00);
        repeat (2) @(negedge clk);
        edge_cnt = 0;
        push(mk(4'hC, 4'hE, 10'd10));
        begin
            int busy_cyc = 0;
            for (int i = 0; i < 500; i++) begin
                @(negedge clk);
                if (status[26:22] == 5'd0) break;
                busy_cyc++;
                if (io_oe != 4'b0000) edge_cnt += 100;
            end
            chk(busy_cyc == 42, "R3 idle duration", busy_cyc, 42);
        end
        chk(edge_cnt == 0, "R3 idle quiet pins", edge_cnt, 0);
        chk(cs_n == 2'b10, "R2 select held after idle", int'(cs_n), 2);

        // R9 unknown type: applies select, no clocks
        push(mk(4'hF, 4'hF, 10'd0));
        wait_idle();
        edge_cnt = 0;
        push(mk(4'h0, 4'hD, 10'h3FF));
        repeat (6) @(negedge clk);
        chk(cs_n == 2'b01, "R9 unknown applies select", int'(cs_n), 1);
        chk(edge_cnt == 0, "R9 unknown no sclk", edge_cnt, 0);
        chk(status[26:22] == 5'd0, "R9 unknown retires", int'(status[26:22]), 0);
        push(mk(4'hC, 4'hF, 10'd0));
        wait_idle();

        // R7 pending spans FIFO, prefetch and executor
        push(mk(4'hC, 4'hF, 10'd50));
        push(mk(4'hC, 4'hF, 10'd50));
        push(mk(4'hC, 4'hF, 10'd50));
        repeat (5) @(negedge clk);
        chk(status[26:22] == 5'd3, "R7 pending count", int'(status[26:22]), 3);
        chk(status[31] == 1'b0, "R8 no overflow yet", int'(status[31]), 0);
        wait_idle();
        chk(status[26:22] == 5'd0, "R7 drained", int'(status[26:22]), 0);

        // R8 burst overflow: depth 8 + prefetch + executor accept 10 of 14
        for (int i = 0; i < 14; i++) push(mk(4'hC, 4'hF, 10'd100));
        @(negedge clk);
        chk(status[31] == 1'b1, "R8 overflow flag", int'(status[31]), 1);
        chk(status[26:22] == 5'd10, "R8 accepted count", int'(status[26:22]), 10);
        wait_idle();
        chk(status[26:22] == 5'd0, "R7 burst drained", int'(status[26:22]), 0);
        chk(status[31] == 1'b1, "R8 flag sticky", int'(status[31]), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule